// File: doc/BRIEF.md
# Prescaled Real-Time Counter with Period and Compare Match

This block is a 16-bit timekeeping counter for a slow, always-on clock domain. A 15-bit prescaler divides the incoming clock by a power of two and produces a count tick. Each tick advances the counter. A period register sets the wrap value and a compare register sets a match point. Both matches are judged on the tick that follows equality: the tick that finds the counter equal to the period value loads zero and raises the overflow flag, and the tick that finds it equal to the compare value raises the compare flag. Each flag has its own interrupt enable. The interrupt line is high while any enabled flag is set. A one-cycle event pulse marks the cycle in which each flag gets set.

Software reaches every register through a flat write/read port with a 3-bit address. A small state machine sets whether the prescaler and counter advance. It has three states:
- ST_OFF: the enable bit is clear.
- ST_RUN: the block counts.
- ST_HOLD: the block is paused by a standby or debug-halt condition that the configuration does not override.

The state machine has four transitions:
- EN_ON: ST_OFF to ST_RUN or ST_HOLD.
- EN_OFF: any state to ST_OFF.
- PAUSE: ST_RUN to ST_HOLD.
- RESUME: ST_HOLD to ST_RUN.

The state register updates on the clock edge that follows an input or control change. Counting therefore follows such a change one cycle late.

Top module: `rtc_tick_counter`

## Requirements
- R1: After reset the period register reads 0xFFFF. Every other register reads zero, and `irq`, `evt_ovf` and `evt_cmp` are low.
- R2: A tick that finds the counter equal to the period loads the counter with zero and sets overflow flag bit 0. In the same cycle as the flag sets, `evt_ovf` pulses high for exactly one cycle.
- R3: A tick that finds the counter equal to the compare value sets compare flag bit 1 and pulses `evt_cmp` for one cycle. The counter still advances normally on that tick.
- R4: Control bits 6:3 hold a code N. While the block runs, a tick occurs every 2^N cycles (N=0 ticks every cycle, N=15 every 32768 cycles).
- R5: With control bit 0 clear, the prescaler and the counter hold their values. A change of control bit 0 takes effect from the second clock edge after the write.
- R6: When `standby` is high and control bit 7 is 0, counting pauses. When bit 7 is 1, the block keeps counting during `standby`.
- R7: When `dbg_halt` is high and debug-run bit 0 at address 6 is 0, counting pauses. When that bit is 1, the block keeps counting during `dbg_halt`.
- R8: Interrupt-enable register (address 4) bit 0 enables overflow and bit 1 enables compare. `irq` equals the OR of each flag ANDed with its enable. Flags set whether or not they are enabled.
- R9: The flag register is at address 5, with the same bit positions as the enables. Writing 1 to a bit clears it and writing 0 leaves it. If a flag is set and cleared in the same cycle, the set wins.
- R10: A write to the counter (address 3) loads the written value and overrides any tick in that cycle. That tick raises neither flag nor event.
- R11: The register map is: 0 control, 1 period, 2 compare, 3 counter, 4 enables, 5 flags, 6 debug-run. Unused bits and address 7 read zero. Control bit 1 reads zero. Control bit 2 (correction enable) is stored and read back but has no effect on counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow timekeeping clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| standby | input | 1 | Standby sleep indication |
| dbg_halt | input | 1 | CPU halted in debug |
| irq | output | 1 | Level interrupt request |
| evt_ovf | output | 1 | One-cycle overflow event |
| evt_cmp | output | 1 | One-cycle compare event |

## Verification
Two pairs of actions can land in the same cycle. The first pair is a flag being set by a match and software clearing that flag. The second pair is a counter write and a tick. The bench provokes the first by running with the period at zero and the prescaler at divide-by-one, so an overflow lands on every cycle, and then writing clear bits; the flag must still read set. It provokes the second by writing the counter while ticks occur every cycle; the written value must appear unchanged, and no event may pulse. Random traffic mixes these cases further, and a cycle-accurate reference model in the bench judges every output and readback.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2
    } run_state_e;

    localparam int ADDR_W = 3;
    localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] A_PER  = 3'd1;
    localparam logic [ADDR_W-1:0] A_CMP  = 3'd2;
    localparam logic [ADDR_W-1:0] A_CNT  = 3'd3;
    localparam logic [ADDR_W-1:0] A_IEN  = 3'd4;
    localparam logic [ADDR_W-1:0] A_FLG  = 3'd5;
    localparam logic [ADDR_W-1:0] A_DBG  = 3'd6;

    localparam int CTRL_EN    = 0;
    localparam int CTRL_PS_LO = 3;
    localparam int CTRL_PS_HI = 6;
    localparam int CTRL_RSTBY = 7;
    localparam logic [7:0] CTRL_MASK = 8'hFD;

    localparam int FLG_OVF = 0;
    localparam int FLG_CMP = 1;
    localparam int NFLAGS  = 2;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int PRE_W = 15,
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int FULL_W = PRE_W + 1;

    logic [PRE_W-1:0]  pre_q;
    logic [FULL_W-1:0] full;
    logic [PRE_W-1:0]  mask;

    always_comb begin
        full = ({{PRE_W{1'b0}}, 1'b1} << sel) - FULL_W'(1);
        mask = full[PRE_W-1:0];
        tick = run && ((pre_q & mask) == mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   pre_q <= '0;
        else if (run) pre_q <= pre_q + PRE_W'(1);
    end
endmodule

// File: rtl/rtc_count_core.sv
module rtc_count_core #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         cnt_wr,
    input  logic [W-1:0] cnt_wdata,
    input  logic [W-1:0] per,
    input  logic [W-1:0] cmp,
    output logic [W-1:0] cnt,
    output logic [1:0]   hit,
    output logic         ovf_evt,
    output logic         cmp_evt
);
    logic [W-1:0] cnt_q;
    logic ovf_eq, cmp_eq, live;

    always_comb begin
        ovf_eq = (cnt_q == per);
        cmp_eq = (cnt_q == cmp);
        live   = tick && !cnt_wr;
        hit    = {live && cmp_eq, live && ovf_eq};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            ovf_evt <= 1'b0;
            cmp_evt <= 1'b0;
        end else begin
            if (cnt_wr)    cnt_q <= cnt_wdata;
            else if (tick) cnt_q <= ovf_eq ? '0 : cnt_q + W'(1);
            ovf_evt <= hit[0];
            cmp_evt <= hit[1];
        end
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/rtc_flags.sv
module rtc_flags #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic         clr_stb,
    input  logic [N-1:0] clr_mask,
    output logic [N-1:0] flags
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                      flags[i] <= 1'b0;
            else if (set[i])                 flags[i] <= 1'b1;
            else if (clr_stb && clr_mask[i]) flags[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/rtc_tick_counter.sv
module rtc_tick_counter #(
    parameter int CNT_W = 16,
    parameter int PRE_W = 15,
    parameter int SEL_W = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       reg_wr,
    input  logic [rtc_pkg::ADDR_W-1:0] reg_addr,
    input  logic [CNT_W-1:0]           reg_wdata,
    output logic [CNT_W-1:0]           reg_rdata,
    input  logic                       standby,
    input  logic                       dbg_halt,
    output logic                       irq,
    output logic                       evt_ovf,
    output logic                       evt_cmp
);
    import rtc_pkg::*;

    localparam int NF = NFLAGS;

    run_state_e state_q, state_d;
    logic [7:0]       ctrl_q;
    logic [CNT_W-1:0] per_q, cmp_q, cnt_q;
    logic [NF-1:0]    ien_q, flags, hit;
    logic             dbg_q;
    logic             en, hold, run, tick, cnt_wr, flg_wr;
    logic [SEL_W-1:0] presc;

    assign en     = ctrl_q[CTRL_EN];
    assign presc  = ctrl_q[CTRL_PS_HI:CTRL_PS_LO];
    assign hold   = (standby && !ctrl_q[CTRL_RSTBY]) || (dbg_halt && !dbg_q);
    assign cnt_wr = reg_wr && (reg_addr == A_CNT);
    assign flg_wr = reg_wr && (reg_addr == A_FLG);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:  if (en) state_d = hold ? ST_HOLD : ST_RUN;  // EN_ON
            ST_RUN:  if (!en) state_d = ST_OFF;                  // EN_OFF
                     else if (hold) state_d = ST_HOLD;           // PAUSE
            ST_HOLD: if (!en) state_d = ST_OFF;                  // EN_OFF
                     else if (!hold) state_d = ST_RUN;           // RESUME
            default: state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // outputs of the state machine
    always_comb begin
        run = (state_q == ST_RUN);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            per_q  <= '1;
            cmp_q  <= '0;
            ien_q  <= '0;
            dbg_q  <= 1'b0;
        end else if (reg_wr) begin
            case (reg_addr)
                A_CTRL:  ctrl_q <= reg_wdata[7:0] & CTRL_MASK;
                A_PER:   per_q  <= reg_wdata;
                A_CMP:   cmp_q  <= reg_wdata;
                A_IEN:   ien_q  <= reg_wdata[NF-1:0];
                A_DBG:   dbg_q  <= reg_wdata[0];
                default: ;
            endcase
        end
    end

    rtc_prescaler #(.PRE_W(PRE_W), .SEL_W(SEL_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(run), .sel(presc), .tick(tick)
    );

    rtc_count_core #(.W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_wr(cnt_wr),
        .cnt_wdata(reg_wdata), .per(per_q), .cmp(cmp_q), .cnt(cnt_q),
        .hit(hit), .ovf_evt(evt_ovf), .cmp_evt(evt_cmp)
    );

    rtc_flags #(.N(NF)) u_flg (
        .clk(clk), .rst_n(rst_n), .set(hit), .clr_stb(flg_wr),
        .clr_mask(reg_wdata[NF-1:0]), .flags(flags)
    );

    assign irq = |(flags & ien_q);

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CTRL:  reg_rdata = CNT_W'(ctrl_q);
            A_PER:   reg_rdata = per_q;
            A_CMP:   reg_rdata = cmp_q;
            A_CNT:   reg_rdata = cnt_q;
            A_IEN:   reg_rdata = CNT_W'(ien_q);
            A_FLG:   reg_rdata = CNT_W'(flags);
            A_DBG:   reg_rdata = CNT_W'(dbg_q);
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/rtc_tick_counter_chk.sv
module rtc_tick_counter_chk (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       reg_wr,
    input logic [rtc_pkg::ADDR_W-1:0] reg_addr,
    input rtc_pkg::run_state_e        state,
    input logic [15:0]                cnt,
    input logic                       tick,
    input logic [3:0]                 presc,
    input logic [1:0]                 flags,
    input logic                       evt_ovf,
    input logic                       evt_cmp
);
    import rtc_pkg::*;

    assert_ovf_wraps_R2: assert property (@(posedge clk) disable iff (!rst_n)
        evt_ovf |-> (cnt == 16'd0 && flags[FLG_OVF]));

    assert_cmp_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        evt_cmp |-> flags[FLG_CMP]);

    assert_tick_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && presc != 4'd0 && !(reg_wr && reg_addr == A_CTRL)) |=> !tick);

    assert_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF && !(reg_wr && reg_addr == A_CNT)) |=> $stable(cnt));
endmodule

bind rtc_tick_counter rtc_tick_counter_chk u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .state(state_q), .cnt(cnt_q), .tick(tick), .presc(presc),
    .flags(flags), .evt_ovf(evt_ovf), .evt_cmp(evt_cmp)
);

// File: tb/sim_rtc_tick_counter.sv
`timescale 1ns/1ps
module sim_rtc_tick_counter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic [15:0] reg_rdata;
    logic        standby = 1'b0;
    logic        dbg_halt = 1'b0;
    logic        irq, evt_ovf, evt_cmp;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    rtc_tick_counter u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .standby(standby),
        .dbg_halt(dbg_halt), .irq(irq), .evt_ovf(evt_ovf), .evt_cmp(evt_cmp)
    );

    // reference model, built from the requirements
    int          m_state;
    logic [14:0] m_pre, mk;
    logic [15:0] m_cnt, m_per, m_cmp;
    logic [7:0]  m_ctrl;
    logic [1:0]  m_ien, m_flags;
    logic        m_dbg, m_eo, m_ec;
    logic        t_tick, t_cw, t_oh, t_ch, t_hold;
    int          t_ns;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_state = 0; m_pre = '0; m_cnt = '0; m_per = 16'hFFFF; m_cmp = '0;
            m_ctrl = '0; m_ien = '0; m_flags = '0; m_dbg = 1'b0; m_eo = 1'b0; m_ec = 1'b0;
        end else begin
            mk     = 15'((32'd1 << m_ctrl[6:3]) - 32'd1);
            t_tick = (m_state == 1) && ((m_pre & mk) == mk);
            t_cw   = reg_wr && reg_addr == 3'd3;
            t_oh   = t_tick && !t_cw && (m_cnt == m_per);
            t_ch   = t_tick && !t_cw && (m_cnt == m_cmp);
            t_hold = (standby && !m_ctrl[7]) || (dbg_halt && !m_dbg);
            t_ns   = !m_ctrl[0] ? 0 : (t_hold ? 2 : 1);
            if (m_state == 1) m_pre = m_pre + 15'd1;
            if (t_cw) m_cnt = reg_wdata;
            else if (t_tick) m_cnt = (m_cnt == m_per) ? 16'd0 : m_cnt + 16'd1;
            if (reg_wr && reg_addr == 3'd5) m_flags = m_flags & ~reg_wdata[1:0];
            m_flags = m_flags | {t_ch, t_oh};
            m_eo = t_oh; m_ec = t_ch; m_state = t_ns;
            if (reg_wr) case (reg_addr)
                3'd0: m_ctrl = reg_wdata[7:0] & 8'hFD;
                3'd1: m_per  = reg_wdata;
                3'd2: m_cmp  = reg_wdata;
                3'd4: m_ien  = reg_wdata[1:0];
                3'd6: m_dbg  = reg_wdata[0];
                default: ;
            endcase
        end
    end

    function automatic logic [15:0] model_read(input logic [2:0] a);
        case (a)
            3'd0: return {8'h00, m_ctrl};
            3'd1: return m_per;
            3'd2: return m_cmp;
            3'd3: return m_cnt;
            3'd4: return {14'd0, m_ien};
            3'd5: return {14'd0, m_flags};
            3'd6: return {15'd0, m_dbg};
            default: return 16'd0;
        endcase
    endfunction

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input logic w, input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        chk({15'd0, evt_ovf}, {15'd0, m_eo}, "R2 evt_ovf");
        chk({15'd0, evt_cmp}, {15'd0, m_ec}, "R3 evt_cmp");
        chk({15'd0, irq}, {15'd0, |(m_flags & m_ien)}, "R8 irq");
        reg_wr = w; reg_addr = a; reg_wdata = d;
        #1;
        if (!w) chk(reg_rdata, model_read(a), "R11 readback");
    endtask

    task automatic idle(input int n, input logic [2:0] a);
        for (int i = 0; i < n; i++) step(1'b0, a, 16'd0);
    endtask

    logic [15:0] va, vb;

    initial begin
        void'($urandom(32'd20240611));
        #12 rst_n = 1'b1;

        // R1 reset values
        step(1'b0, 3'd1, 0); chk(reg_rdata, 16'hFFFF, "R1 period reset");
        step(1'b0, 3'd0, 0); chk(reg_rdata, 16'h0000, "R1 ctrl reset");
        step(1'b0, 3'd5, 0); chk(reg_rdata, 16'h0000, "R1 flags reset");
        chk({13'd0, irq, evt_ovf, evt_cmp}, 16'd0, "R1 outputs reset");

        // R4 divide by 4: ticks on 5th,9th,13th,17th edge after the write
        step(1'b1, 3'd0, 16'h0011);
        idle(21, 3'd3);
        chk(reg_rdata, 16'd4, "R4 prescale count");

        // R5 disable freezes
        step(1'b1, 3'd0, 16'h0010);
        idle(2, 3'd3); va = reg_rdata;
        idle(10, 3'd3);
        chk(reg_rdata, va, "R5 frozen counter");

        // R10 counter write
        step(1'b1, 3'd0, 16'h0001);
        idle(3, 3'd3);
        step(1'b1, 3'd3, 16'd100);
        step(1'b0, 3'd3, 0);
        chk(reg_rdata, 16'd100, "R10 write overrides tick");

        // R2/R3 with small period
        step(1'b1, 3'd1, 16'd3);
        step(1'b1, 3'd2, 16'd1);
        step(1'b1, 3'd3, 16'd0);
        step(1'b1, 3'd4, 16'd3);
        idle(8, 3'd5);
        chk(reg_rdata, 16'd3, "R2 R3 flags set");

        // R9 set wins over clear: period 0, every tick overflows
        step(1'b1, 3'd1, 16'd0);
        step(1'b1, 3'd3, 16'd0);
        idle(2, 3'd5);
        step(1'b1, 3'd5, 16'd1);
        step(1'b0, 3'd5, 0);
        chk(reg_rdata & 16'd1, 16'd1, "R9 set beats clear");
        step(1'b1, 3'd0, 16'h0000);
        idle(2, 3'd5);
        step(1'b1, 3'd5, 16'd3);
        step(1'b0, 3'd5, 0);
        chk(reg_rdata, 16'd0, "R9 write one clears");

        // R8 disabled enables hide flags
        step(1'b1, 3'd4, 16'd0);
        step(1'b1, 3'd0, 16'h0001);
        idle(4, 3'd5);
        chk({15'd0, irq}, 16'd0, "R8 irq masked");
        chk(reg_rdata & 16'd1, 16'd1, "R8 flag set while masked");

        // R6 standby
        step(1'b1, 3'd1, 16'hFFFF);
        step(1'b1, 3'd3, 16'd0);
        standby = 1'b1;
        idle(3, 3'd3); va = reg_rdata;
        idle(5, 3'd3); vb = reg_rdata;
        chk(vb, va, "R6 standby pauses");
        step(1'b1, 3'd0, 16'h0081);
        idle(3, 3'd3); va = reg_rdata;
        idle(5, 3'd3); vb = reg_rdata;
        chk(vb, va + 16'd5, "R6 run in standby");
        standby = 1'b0;

        // R7 debug halt
        dbg_halt = 1'b1;
        idle(3, 3'd3); va = reg_rdata;
        idle(5, 3'd3); vb = reg_rdata;
        chk(vb, va, "R7 debug pauses");
        step(1'b1, 3'd6, 16'd1);
        idle(3, 3'd3); va = reg_rdata;
        idle(5, 3'd3); vb = reg_rdata;
        chk(vb, va + 16'd5, "R7 debug run");
        dbg_halt = 1'b0;

        // R11 correction bit stored, bit 1 dropped
        step(1'b1, 3'd0, 16'h00FF);
        step(1'b0, 3'd0, 0);
        chk(reg_rdata, 16'h00FD, "R11 ctrl readback");
        step(1'b0, 3'd7, 0);
        chk(reg_rdata, 16'h0000, "R11 unused address");

        // random traffic
        for (int n = 0; n < 4000; n++) begin
            int r;
            logic [2:0] a;
            logic [15:0] d;
            r = $urandom_range(0, 99);
            a = 3'($urandom_range(0, 7));
            if (r < 15) begin
                case (a)
                    3'd0: d = {8'h00, 1'($urandom_range(0, 1)), 4'($urandom_range(0, 3)),
                               1'($urandom_range(0, 1)), 1'b0, 1'($urandom_range(0, 5) != 0)};
                    3'd1, 3'd2, 3'd3: d = 16'($urandom_range(0, 12));
                    default: d = 16'($urandom);
                endcase
                step(1'b1, a, d);
            end else begin
                if (r > 96) standby = ~standby;
                if (r == 96) dbg_halt = ~dbg_halt;
                step(1'b0, a, 16'd0);
            end
        end

        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #500000;
        if (!done) begin
            done = 1;
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule